// File: doc/BRIEF.md
# Bus Error Machine Check Controller

This block sits beside a processor's bus interface and turns an error reported by the system into either a machine check exception or a checkstop. Two active-low error pins feed it. One reports a failed transfer. The other is a dedicated machine-check pin that software can mask with its own enable bit. An error counts only while a bus transaction is in progress. When an error is accepted, the block ends the transaction with a one-cycle terminate strobe. It stops driving the data bus on the following clock.

If machine checks are enabled, the block raises an exception request at once, whatever else is happening. It presents the faulting address alongside the request and cancels every completed store still queued for the bus. If machine checks are disabled, the block enters a checkstop that only reset can clear. Contents already written into registers or cache are left alone. A bus error exception wins over any exception raised by the instruction that started the bus operation.

Top module: `buserr_mchk_ctrl`

## Requirements
- R1: The error pins are active-low (0 = error) and are sampled on the rising clock edge. A sampled error is accepted only when `xact_active` was 1 at that same edge. An accepted error raises `xact_term` for exactly one cycle, in the cycle that follows the sampling edge. An error held over several edges produces only one event.
- R2: When `mpin_en` is 0, `mchk_pin_n` has no effect on any output. When `mpin_en` is 1, a low `mchk_pin_n` is an error just like a low `xfer_err_n`.
- R3: `dbus_oe` is a register that follows `xact_active` one edge late. On the clock edge that ends the event cycle it is forced to 0, so the data bus is released exactly one clock after the error was sampled.
- R4: An event whose sampling edge saw `mchk_en` = 1 raises `mchk_exc` in the event cycle, unless checkstop is already set.
- R5: `saved_addr` takes the value `fault_addr` had at the sampling edge of each event. It is valid together with `mchk_exc` and holds until the next event. It is 0 after reset.
- R6: `store_cancel` pulses in exactly the cycles in which `mchk_exc` is 1.
- R7: An event whose sampling edge saw `mchk_en` = 0 sets `checkstop` in the event cycle. It raises neither `mchk_exc` nor `store_cancel`.
- R8: `checkstop` stays 1 until reset. While it is set, later events still produce `xact_term` but never `mchk_exc` or `store_cancel`.
- R9: `insn_exc_grant` equals `insn_exc_req` except in a cycle where `mchk_exc` is 1, when it is 0.
- R10: During and right after reset, `mchk_exc`, `xact_term`, `store_cancel`, `checkstop`, `dbus_oe` and `insn_exc_grant` (with no request pending) are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_err_n | input | 1 | Transfer-error pin, active low |
| mchk_pin_n | input | 1 | Machine-check pin, active low |
| mchk_en | input | 1 | 1 = take an exception on error, 0 = checkstop |
| mpin_en | input | 1 | 1 = honour the machine-check pin |
| xact_active | input | 1 | A bus transaction is in progress |
| fault_addr | input | ADDR_W | Address of the access in flight |
| insn_exc_req | input | 1 | Exception request from the instruction that started the access |
| mchk_exc | output | 1 | Machine check exception request |
| saved_addr | output | ADDR_W | Address captured with the latest event |
| xact_term | output | 1 | One-cycle transaction terminate strobe |
| dbus_oe | output | 1 | Data bus output enable |
| store_cancel | output | 1 | Cancel all pending completed stores |
| checkstop | output | 1 | Sticky checkstop flag |
| insn_exc_grant | output | 1 | Instruction exception allowed to proceed |

## Verification
A stale edge-detect register would show as a second `xact_term` pulse, or a missing one, when an error pin is held low. This is visible one cycle after the second sampling edge. A wrong sticky checkstop state shows at once: `checkstop` may drop during idle cycles, or `mchk_exc` may reappear on the next event. An enable register that does not release the bus shows `dbus_oe` still high one clock after the terminate strobe. A stale address capture register shows as a `saved_addr` mismatch in the event cycle itself.

// File: rtl/buserr_mchk_pkg.sv
package buserr_mchk_pkg;
   // captured view of one sampling edge
   typedef struct packed {
      logic hit;      // qualified error seen at this edge
      logic mchk_en;  // exception enable at this edge
   } smp_t;

   // per-cycle response of the decision stage
   typedef struct packed {
      logic term;
      logic exc;
      logic cancel;
      logic halt;
   } resp_t;
endpackage

// File: rtl/buserr_sample.sv
module buserr_sample
   import buserr_mchk_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter bit ERR_ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_err_pin,
   input  logic              mchk_pin,
   input  logic              mpin_en,
   input  logic              mchk_en,
   input  logic              xact_active,
   input  logic [ADDR_W-1:0] fault_addr,
   output smp_t              smp_q,
   output logic              prev_hit_q,
   output logic [ADDR_W-1:0] saved_addr_q
);
   logic te_act;
   logic mc_act;
   logic hit_d;

   // polarity variant
   if (ERR_ACTIVE_LOW) begin : g_low
      assign te_act = ~xfer_err_pin;
      assign mc_act = ~mchk_pin;
   end else begin : g_high
      assign te_act = xfer_err_pin;
      assign mc_act = mchk_pin;
   end

   assign hit_d = xact_active & (te_act | (mpin_en & mc_act));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q        <= '0;
         prev_hit_q   <= 1'b0;
         saved_addr_q <= '0;
      end else begin
         smp_q.hit     <= hit_d;
         smp_q.mchk_en <= mchk_en;
         prev_hit_q    <= smp_q.hit;
         if (hit_d && !smp_q.hit) begin
            saved_addr_q <= fault_addr;
         end
      end
   end
endmodule

// File: rtl/buserr_event.sv
module buserr_event
   import buserr_mchk_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  smp_t  smp_q,
   input  logic  prev_hit_q,
   input  logic  insn_exc_req,
   output resp_t resp,
   output logic  insn_exc_grant
);
   logic evt;
   logic halt_q;

   assign evt         = smp_q.hit & ~prev_hit_q;
   assign resp.term   = evt;
   assign resp.exc    = evt & smp_q.mchk_en & ~halt_q;
   assign resp.cancel = resp.exc;
   assign resp.halt   = halt_q | (evt & ~smp_q.mchk_en);

   // bus error outranks the instruction's own exception
   assign insn_exc_grant = insn_exc_req & ~resp.exc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= 1'b0;
      end else begin
         halt_q <= resp.halt;
      end
   end
endmodule

// File: rtl/buserr_oe.sv
module buserr_oe (
   input  logic clk,
   input  logic rst_n,
   input  logic xact_active,
   input  logic term,
   output logic dbus_oe
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dbus_oe <= 1'b0;
      end else begin
         dbus_oe <= xact_active & ~term;
      end
   end
endmodule

// File: rtl/buserr_mchk_ctrl.sv
module buserr_mchk_ctrl
   import buserr_mchk_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter bit ERR_ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_err_n,
   input  logic              mchk_pin_n,
   input  logic              mchk_en,
   input  logic              mpin_en,
   input  logic              xact_active,
   input  logic [ADDR_W-1:0] fault_addr,
   input  logic              insn_exc_req,
   output logic              mchk_exc,
   output logic [ADDR_W-1:0] saved_addr,
   output logic              xact_term,
   output logic              dbus_oe,
   output logic              store_cancel,
   output logic              checkstop,
   output logic              insn_exc_grant
);
   if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_width
      $error("buserr_mchk_ctrl: ADDR_W must be 1..64");
   end

   smp_t  smp_q;
   logic  prev_hit_q;
   resp_t resp;

   buserr_sample #(
      .ADDR_W         (ADDR_W),
      .ERR_ACTIVE_LOW (ERR_ACTIVE_LOW)
   ) u_sample (
      .clk          (clk),
      .rst_n        (rst_n),
      .xfer_err_pin (xfer_err_n),
      .mchk_pin     (mchk_pin_n),
      .mpin_en      (mpin_en),
      .mchk_en      (mchk_en),
      .xact_active  (xact_active),
      .fault_addr   (fault_addr),
      .smp_q        (smp_q),
      .prev_hit_q   (prev_hit_q),
      .saved_addr_q (saved_addr)
   );

   buserr_event u_event (
      .clk            (clk),
      .rst_n          (rst_n),
      .smp_q          (smp_q),
      .prev_hit_q     (prev_hit_q),
      .insn_exc_req   (insn_exc_req),
      .resp           (resp),
      .insn_exc_grant (insn_exc_grant)
   );

   buserr_oe u_oe (
      .clk         (clk),
      .rst_n       (rst_n),
      .xact_active (xact_active),
      .term        (resp.term),
      .dbus_oe     (dbus_oe)
   );

   assign xact_term    = resp.term;
   assign mchk_exc     = resp.exc;
   assign store_cancel = resp.cancel;
   assign checkstop    = resp.halt;
endmodule

// File: rtl/buserr_mchk_ctrl_chk.sv
module buserr_mchk_ctrl_chk #(
   parameter int ADDR_W         = 32,
   parameter bit ERR_ACTIVE_LOW = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              xfer_err_n,
   input logic              mchk_pin_n,
   input logic              mchk_en,
   input logic              mpin_en,
   input logic              xact_active,
   input logic [ADDR_W-1:0] fault_addr,
   input logic              insn_exc_req,
   input logic              mchk_exc,
   input logic [ADDR_W-1:0] saved_addr,
   input logic              xact_term,
   input logic              dbus_oe,
   input logic              store_cancel,
   input logic              checkstop,
   input logic              insn_exc_grant
);
   logic te_on;
   logic mc_on;
   assign te_on = ERR_ACTIVE_LOW ? ~xfer_err_n : xfer_err_n;
   assign mc_on = ERR_ACTIVE_LOW ? ~mchk_pin_n : mchk_pin_n;

   assert_term_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      xact_term |=> !xact_term);

   assert_term_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      xact_term |-> $past(xact_active && (te_on || (mpin_en && mc_on))));

   assert_bus_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      xact_term |=> !dbus_oe);

   assert_oe_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(xact_active) |-> !dbus_oe);

   assert_exc_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (xact_term && $past(mchk_en) && !$past(checkstop)) |-> mchk_exc);

   assert_addr_saved_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mchk_exc |-> (saved_addr == $past(fault_addr)));

   assert_cancel_with_exc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      store_cancel |-> mchk_exc);

   assert_exc_with_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mchk_exc |-> store_cancel);

   assert_halt_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (xact_term && !$past(mchk_en)) |-> (checkstop && !mchk_exc));

   assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(checkstop) |-> checkstop);

   assert_halt_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(checkstop) |-> !mchk_exc);

   assert_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mchk_exc |-> !insn_exc_grant);
endmodule

bind buserr_mchk_ctrl buserr_mchk_ctrl_chk #(
   .ADDR_W         (ADDR_W),
   .ERR_ACTIVE_LOW (ERR_ACTIVE_LOW)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .xfer_err_n     (xfer_err_n),
   .mchk_pin_n     (mchk_pin_n),
   .mchk_en        (mchk_en),
   .mpin_en        (mpin_en),
   .xact_active    (xact_active),
   .fault_addr     (fault_addr),
   .insn_exc_req   (insn_exc_req),
   .mchk_exc       (mchk_exc),
   .saved_addr     (saved_addr),
   .xact_term      (xact_term),
   .dbus_oe        (dbus_oe),
   .store_cancel   (store_cancel),
   .checkstop      (checkstop),
   .insn_exc_grant (insn_exc_grant)
);

// File: tb/buserr_mchk_ctrl_bench.sv
`timescale 1ns/1ps
module buserr_mchk_ctrl_bench;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          xfer_err_n = 1'b1;
   logic          mchk_pin_n = 1'b1;
   logic          mchk_en = 1'b1;
   logic          mpin_en = 1'b1;
   logic          xact_active = 1'b0;
   logic [AW-1:0] fault_addr = '0;
   logic          insn_exc_req = 1'b0;
   logic          mchk_exc;
   logic [AW-1:0] saved_addr;
   logic          xact_term;
   logic          dbus_oe;
   logic          store_cancel;
   logic          checkstop;
   logic          insn_exc_grant;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [AW-1:0] exp_saved = '0;

   always #10 clk = ~clk;

   buserr_mchk_ctrl #(.ADDR_W(AW)) u_buserr_mchk_ctrl (
      .clk(clk), .rst_n(rst_n), .xfer_err_n(xfer_err_n), .mchk_pin_n(mchk_pin_n),
      .mchk_en(mchk_en), .mpin_en(mpin_en), .xact_active(xact_active),
      .fault_addr(fault_addr), .insn_exc_req(insn_exc_req), .mchk_exc(mchk_exc),
      .saved_addr(saved_addr), .xact_term(xact_term), .dbus_oe(dbus_oe),
      .store_cancel(store_cancel), .checkstop(checkstop), .insn_exc_grant(insn_exc_grant)
   );

   task automatic chk(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic idle();
      xfer_err_n = 1'b1; mchk_pin_n = 1'b1; mchk_en = 1'b1; mpin_en = 1'b1;
      xact_active = 1'b1; insn_exc_req = 1'b0;
   endtask

   // bits: [8]te_n [7]mp_n [6]men [5]pen [4]act [3]ins | [2]term [1]exc [0]grant
   localparam logic [8:0] VEC [0:8] = '{
      9'b1_1_1_1_1_0_000,
      9'b0_1_1_1_1_0_110,
      9'b1_0_1_1_1_0_110,
      9'b1_0_1_0_1_0_000,
      9'b1_0_1_0_1_1_001,
      9'b0_1_1_0_1_1_110,
      9'b0_0_1_1_1_1_110,
      9'b0_1_1_1_0_0_000,
      9'b1_1_1_1_1_1_001
   };

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      idle();
      xact_active = 1'b0;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 exc", {31'd0, mchk_exc}, '0);
      chk("R10 term", {31'd0, xact_term}, '0);
      chk("R10 checkstop", {31'd0, checkstop}, '0);
      chk("R10 oe", {31'd0, dbus_oe}, '0);
      chk("R10 cancel", {31'd0, store_cancel}, '0);
      chk("R10 grant", {31'd0, insn_exc_grant}, '0);
      chk("R10 R5 addr", saved_addr, '0);
      rst_n = 1'b1;
      idle();
      repeat (2) @(negedge clk);

      // table walk: R1 R2 R3 R4 R5 R6 R9
      for (int i = 0; i < 9; i++) begin
         logic [8:0] v;
         v = VEC[i];
         xfer_err_n = v[8]; mchk_pin_n = v[7]; mchk_en = v[6]; mpin_en = v[5];
         xact_active = v[4]; insn_exc_req = v[3];
         fault_addr = 32'hA000_0000 + 32'(i * 16);
         if (v[2]) exp_saved = fault_addr;
         @(negedge clk);
         chk($sformatf("R1 R2 term v%0d", i), {31'd0, xact_term}, {31'd0, v[2]});
         chk($sformatf("R4 exc v%0d", i), {31'd0, mchk_exc}, {31'd0, v[1]});
         chk($sformatf("R6 cancel v%0d", i), {31'd0, store_cancel}, {31'd0, v[1]});
         chk($sformatf("R9 grant v%0d", i), {31'd0, insn_exc_grant}, {31'd0, v[0]});
         chk($sformatf("R5 addr v%0d", i), saved_addr, exp_saved);
         chk($sformatf("R3 oe follows v%0d", i), {31'd0, dbus_oe}, {31'd0, v[4]});
         chk($sformatf("R8 no halt v%0d", i), {31'd0, checkstop}, '0);
         idle();
         @(negedge clk);
         chk($sformatf("R3 oe release v%0d", i), {31'd0, dbus_oe}, {31'd0, ~v[2]});
         chk($sformatf("R1 strobe v%0d", i), {31'd0, xact_term}, '0);
         @(negedge clk);
      end

      // R1 held error: one event, address of first edge kept (R5)
      begin
         int pulses = 0;
         xfer_err_n = 1'b0;
         for (int k = 0; k < 4; k++) begin
            fault_addr = 32'hB000_0000 + 32'(k);
            @(negedge clk);
            if (xact_term) pulses++;
         end
         idle();
         @(negedge clk);
         if (xact_term) pulses++;
         chk("R1 held single event", 32'(pulses), 32'd1);
         chk("R5 held addr", saved_addr, 32'hB000_0000);
         @(negedge clk);
         chk("R5 addr holds", saved_addr, 32'hB000_0000);
      end

      // R7 checkstop entry
      mchk_en = 1'b0; xfer_err_n = 1'b0; fault_addr = 32'hC000_0010;
      @(negedge clk);
      chk("R7 term", {31'd0, xact_term}, 32'd1);
      chk("R7 checkstop", {31'd0, checkstop}, 32'd1);
      chk("R7 no exc", {31'd0, mchk_exc}, '0);
      chk("R7 no cancel", {31'd0, store_cancel}, '0);
      idle();
      repeat (3) @(negedge clk);
      chk("R8 sticky", {31'd0, checkstop}, 32'd1);

      // R8 later event while halted
      mchk_en = 1'b1; mchk_pin_n = 1'b0; insn_exc_req = 1'b1;
      @(negedge clk);
      chk("R8 term while halted", {31'd0, xact_term}, 32'd1);
      chk("R8 no exc while halted", {31'd0, mchk_exc}, '0);
      chk("R8 no cancel while halted", {31'd0, store_cancel}, '0);
      chk("R9 grant while halted", {31'd0, insn_exc_grant}, 32'd1);
      chk("R8 still halted", {31'd0, checkstop}, 32'd1);
      idle();
      @(negedge clk);

      // R10 reset clears checkstop
      rst_n = 1'b0;
      @(negedge clk);
      chk("R10 halt cleared", {31'd0, checkstop}, '0);
      chk("R10 oe cleared", {31'd0, dbus_oe}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 halt stays clear", {31'd0, checkstop}, '0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule